// File: doc/BRIEF.md
# Packet Timestamp Seconds Extender

Packets carry a compact 32-bit timestamp with a full nanoseconds count and only the two lowest bits of the seconds count. This block turns each compact timestamp into a full seconds-plus-nanoseconds time. It does so against a reference seconds value held in an internal register, which an outside path reloads about every two seconds from a snapshot of the time-of-day counter.

The block takes the two compact seconds bits minus the two low bits of the reference, modulo four. A result of three is read as one second before the reference. Results of zero, one and two are read as that many seconds after it. The nanoseconds field passes through unchanged. Each conversion samples the reference once, in the cycle where the input strobe is high. The result appears one cycle later with its own strobe. A reference reload in the same cycle as a conversion takes effect only for later conversions.

Top module: `ts_sec_extend`

## Requirements
- R1: During reset and after it, until the first conversion, `out_valid` is 0 and `out_sec` and `out_nsec` are 0. The reference register also resets to 0.
- R2: `out_valid` is high in the cycle after each cycle where `in_valid` is high, and low in every other cycle.
- R3: `out_nsec` equals bits 29:0 of the `in_stamp` value sampled with `in_valid`.
- R4: With d = (`in_stamp[31:30]` − reference[1:0]) mod 4 and d in {0,1,2}, `out_sec` = reference + d.
- R5: When d = 3, `out_sec` = reference − 1.
- R6: The seconds arithmetic wraps modulo 2^SEC_W. With reference 0 and d = 3 the result is all ones. With reference at its maximum and d ≥ 1 the result wraps through 0.
- R7: When `ref_load` is high, `ref_sec_in` becomes the reference for conversions in later cycles. A conversion in the same cycle as the load uses the previous reference.
- R8: In a cycle after which no conversion was sampled, `out_sec` and `out_nsec` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Compact timestamp strobe |
| in_stamp | input | STAMP_W | Compact timestamp: seconds in the top WRAP_W bits, nanoseconds below |
| ref_load | input | 1 | Load strobe for the reference seconds |
| ref_sec_in | input | SEC_W | New reference seconds value |
| out_valid | output | 1 | Full timestamp strobe |
| out_sec | output | SEC_W | Rebuilt full seconds |
| out_nsec | output | STAMP_W-WRAP_W | Nanoseconds |

## Verification
The bench builds the block with its defaults: 48-bit seconds, a 32-bit stamp and a 2-bit seconds field. With 48-bit seconds, the bench can load references of 0 and 2^48−1 and so reach both directions of modulo wrap in the seconds adder. With the 2-bit field, the bench can force every difference class 0 to 3 directly. Random phases mix same-cycle reloads, back-to-back conversions and idle gaps against a behavioural model.

// File: rtl/ts_sec_extend.sv
module ts_sec_extend #(
  parameter int SEC_W   = 48,
  parameter int STAMP_W = 32,
  parameter int WRAP_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [STAMP_W-1:0]        in_stamp,
  input  logic                      ref_load,
  input  logic [SEC_W-1:0]          ref_sec_in,
  output logic                      out_valid,
  output logic [SEC_W-1:0]          out_sec,
  output logic [STAMP_W-WRAP_W-1:0] out_nsec
);
  localparam int NS_W = STAMP_W - WRAP_W;

  logic [SEC_W-1:0]  ref_q;
  logic [WRAP_W-1:0] wrap_in;
  logic [WRAP_W-1:0] wrap_diff;
  logic              back_one;
  logic [SEC_W-1:0]  sec_next;

  assign wrap_in   = in_stamp[STAMP_W-1 -: WRAP_W];
  assign wrap_diff = wrap_in - ref_q[WRAP_W-1:0];
  assign back_one  = &wrap_diff;
  assign sec_next  = back_one ? ref_q - SEC_W'(1)
                              : ref_q + SEC_W'(wrap_diff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q     <= '0;
      out_valid <= 1'b0;
      out_sec   <= '0;
      out_nsec  <= '0;
    end else begin
      out_valid <= in_valid;
      if (ref_load) ref_q <= ref_sec_in;
      if (in_valid) begin
        out_sec  <= sec_next;
        out_nsec <= in_stamp[NS_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ts_sec_extend_chk.sv
module ts_sec_extend_chk #(
  parameter int SEC_W   = 48,
  parameter int STAMP_W = 32,
  parameter int WRAP_W  = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic [STAMP_W-1:0]        in_stamp,
  input logic                      ref_load,
  input logic [SEC_W-1:0]          ref_sec_in,
  input logic [SEC_W-1:0]          ref_q,
  input logic                      out_valid,
  input logic [SEC_W-1:0]          out_sec,
  input logic [STAMP_W-WRAP_W-1:0] out_nsec
);
  localparam int NS_W = STAMP_W - WRAP_W;
  localparam logic [SEC_W-1:0] AHEAD_LIM = SEC_W'((1 << WRAP_W) - 1);

  logic [SEC_W-1:0] ref_seen;
  logic [SEC_W-1:0] span;
  always_ff @(posedge clk) ref_seen <= ref_q;
  assign span = out_sec - ref_seen;

  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  nsec_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_nsec == $past(in_stamp[NS_W-1:0]));
  // R4
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_sec[WRAP_W-1:0] == $past(in_stamp[STAMP_W-1 -: WRAP_W]));
  // R5
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (&span) || (span < AHEAD_LIM));
  // R7
  ref_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_load |=> ref_q == $past(ref_sec_in));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sec) && $stable(out_nsec));
endmodule

bind ts_sec_extend ts_sec_extend_chk #(
  .SEC_W(SEC_W), .STAMP_W(STAMP_W), .WRAP_W(WRAP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_stamp(in_stamp),
  .ref_load(ref_load), .ref_sec_in(ref_sec_in), .ref_q(ref_q),
  .out_valid(out_valid), .out_sec(out_sec), .out_nsec(out_nsec)
);

// File: tb/test_ts_sec_extend.sv
`timescale 1ns/100ps
module test_ts_sec_extend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_stamp = '0;
  logic        ref_load = 1'b0;
  logic [47:0] ref_sec_in = '0;
  logic        out_valid;
  logic [47:0] out_sec;
  logic [29:0] out_nsec;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ts_sec_extend i_ts_sec_extend (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_stamp(in_stamp),
    .ref_load(ref_load), .ref_sec_in(ref_sec_in),
    .out_valid(out_valid), .out_sec(out_sec), .out_nsec(out_nsec)
  );

  logic [47:0] m_ref;
  logic        e_valid;
  logic [47:0] e_sec;
  logic [29:0] e_nsec;
  string       e_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ref = '0; e_valid = 1'b0; e_sec = '0; e_nsec = '0; e_tag = "R1";
    end else begin
      if (in_valid) begin
        int d;
        longint s;
        d = (int'(in_stamp[31:30]) - int'(m_ref[1:0]) + 4) % 4;
        s = longint'(m_ref) + ((d == 3) ? -1 : d);
        if (ref_load) e_tag = "R7";
        else if (s < 0 || s >= (longint'(1) << 48)) e_tag = "R6";
        else if (d == 3) e_tag = "R5";
        else e_tag = "R4";
        e_sec = 48'(s);
        e_nsec = in_stamp[29:0];
      end
      e_valid = in_valid;
      if (ref_load) m_ref = ref_sec_in;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(out_valid == e_valid, "R2", longint'(out_valid), longint'(e_valid));
    if (e_valid) begin
      check(out_sec == e_sec, e_tag, longint'(out_sec), longint'(e_sec));
      check(out_nsec == e_nsec, "R3", longint'(out_nsec), longint'(e_nsec));
    end else begin
      check(out_sec == e_sec, "R8", longint'(out_sec), longint'(e_sec));
      check(out_nsec == e_nsec, "R8", longint'(out_nsec), longint'(e_nsec));
    end
  end

  task automatic drive(input bit v, input logic [1:0] s2, input logic [29:0] ns,
                       input bit ld, input logic [47:0] rv);
    @(posedge clk); #1;
    in_valid = v; in_stamp = {s2, ns}; ref_load = ld; ref_sec_in = rv;
  endtask

  task automatic conv(input logic [1:0] s2, input logic [29:0] ns);
    drive(1'b1, s2, ns, 1'b0, '0);
  endtask

  task automatic load(input logic [47:0] rv);
    drive(1'b0, 2'd0, 30'd0, 1'b1, rv);
  endtask

  task automatic idle();
    drive(1'b0, 2'd0, 30'd0, 1'b0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs during reset
    check(out_valid == 1'b0, "R1", longint'(out_valid), 0);
    check(out_sec == '0, "R1", longint'(out_sec), 0);
    check(out_nsec == '0, "R1", longint'(out_nsec), 0);
    rst_n = 1'b1;
    idle(); idle();
    // R1: reference after reset is 0, so compact 3 maps to all ones
    conv(2'd3, 30'd5);
    idle();
    load(48'd100);
    idle();
    conv(2'd0, 30'd0);
    conv(2'd1, 30'h3fff_ffff);
    conv(2'd2, 30'd123456);
    conv(2'd3, 30'd999_999_999);
    idle(); idle();
    load(48'd0);
    conv(2'd3, 30'd7);
    conv(2'd0, 30'd8);
    load(48'hffff_ffff_ffff);
    conv(2'd0, 30'd9);
    conv(2'd1, 30'd10);
    conv(2'd3, 30'd11);
    drive(1'b1, 2'd2, 30'd12, 1'b1, 48'd1000);
    conv(2'd2, 30'd13);
    conv(2'd3, 30'd14);
    idle();
    for (int i = 0; i < 4000; i++) begin
      logic [47:0] rv;
      rv = {16'($urandom), $urandom};
      if ($urandom_range(0, 15) == 0) rv = 48'hffff_ffff_fffe + 48'($urandom_range(0, 3));
      drive($urandom_range(0, 2) != 0, 2'($urandom), 30'($urandom),
            $urandom_range(0, 7) == 0, rv);
    end
    idle(); idle();
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end
endmodule